// File: doc/BRIEF.md
# Power Mode and Clock-Enable Controller

This block sits beside a small 8-bit processor core. It decides which operating mode the core is in and produces, from the master clock, the clock enables for the CPU and for the peripherals, plus the enable for the oscillator. There are six modes: Run, Slow, Wait, Slow-Wait, Active Halt and Halt. Software moves the block between them in two ways. It writes a control word that holds a slow-mode bit and a two-bit divider field. It also executes the wait and halt instructions, which reach the block as one-cycle strobes.

Slow mode divides the master clock by 2, 4, 8 or 16. The enables are then single-cycle pulses, evenly spaced. A new divider value is applied only at a count boundary, so no pulse gap is ever shortened. Wait stops the CPU and keeps the peripherals running at their current rate. Any interrupt returns the core to the rate it came from. The halt instruction has two outcomes, chosen by the oscillator-keep-running flag. With the flag set, the block enters Active Halt: every enable is low and the oscillator stays on. With the flag clear, it enters Halt: the oscillator stops as well, and only an external interrupt or a reset can wake it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the block is in Run, with mode code 0, the CPU and peripheral enables both high and the oscillator enable high. The slow-mode bit and the divider field reset to 0.
- R2: `mode_o` reports the mode as a 3-bit code: Run=0, Slow=1, Wait=2, Slow-Wait=3, Active Halt=4, Halt=5. No other value ever appears.
- R3: A cycle with `cfg_we_i` high loads `cfg_slow_i` and `cfg_div_i`. In Run, when the stored slow bit is 1 and neither strobe is present, the block enters Slow on the next clock edge. In Run, both enables are high on every cycle.
- R4: In Slow, the divider field gives a period N: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16. The CPU and peripheral enables pulse together for one cycle every N cycles. The first pulse falls N cycles after Slow is entered.
- R5: A wait strobe in Run leads to Wait. In Wait, the CPU enable is low and the peripheral enable is high on every cycle. `irq_i` or `ext_irq_i` returns the block to Run.
- R6: A wait strobe in Slow leads to Slow-Wait. In Slow-Wait, the CPU enable is low and the peripheral enable keeps the Slow pulse rate with no break in its phase. `irq_i` or `ext_irq_i` returns the block to Slow.
- R7: A halt strobe in Run or Slow with `osc_keep_i`=1 leads to Active Halt. There, both enables are low and the oscillator enable is high. `irq_i` or `ext_irq_i` wakes the block. It wakes to Slow if the stored slow bit is 1, and to Run otherwise.
- R8: A halt strobe in Run or Slow with `osc_keep_i`=0 leads to Halt. There, the oscillator enable and both clock enables are low. `irq_i` has no effect. Only `ext_irq_i` (or reset) wakes the block, to Slow if the slow bit is 1 and to Run otherwise.
- R9: A divider change written while in Slow or Slow-Wait takes effect only after the next pulse. The pulse gap that is running when the write happens keeps its old length.
- R10: When the slow bit is cleared while in Slow, the block stays in Slow until the next pulse and enters Run on the edge that follows that pulse.
- R11: When halt and wait strobes come together, the halt strobe wins. Both strobes are ignored in Wait, Slow-Wait, Active Halt and Halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_slow_i | input | 1 | Slow-mode bit to write |
| cfg_div_i | input | 2 | Slow divider field to write |
| wfi_i | input | 1 | Wait instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| osc_keep_i | input | 1 | Keep oscillator running on halt |
| irq_i | input | 1 | Any enabled interrupt |
| ext_irq_i | input | 1 | External interrupt |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| mode_o | output | 3 | Current mode code |

## Verification
Directed runs program each of the four divider values and measure the gap between pulses. This separates a correct divide from an off-by-one or a wrong shift. A divider write placed just after a pulse must give one gap at the old rate and then gaps at the new rate, which shows whether updates wait for the boundary. The bench also applies a mixed wait-plus-halt strobe, an `irq_i` during Halt and a slow-bit clear during Slow. These tell apart strobe priority, the wake source and the exit timing. Seeded random sequences of writes, strobes and interrupts then run against a cycle model built from the requirements. They catch wrong return modes, for example Slow-Wait waking into Run.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    MODE_RUN   = 3'd0,
    MODE_SLOW  = 3'd1,
    MODE_WAIT  = 3'd2,
    MODE_SWAIT = 3'd3,
    MODE_AHALT = 3'd4,
    MODE_HALT  = 3'd5
  } pmc_mode_e;
endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             slow_i,
  input  logic [SEL_W-1:0] div_i,
  output logic             slow_o,
  output logic [SEL_W-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_o <= 1'b0;
      div_o  <= '0;
    end else if (we_i) begin
      slow_o <= slow_i;
      div_o  <= div_i;
    end
  end
endmodule

// File: rtl/pmc_div.sv
module pmc_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [SEL_W-1:0] act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_m1;

  // period = 2 << act, count runs 0 .. period-1
  always_comb begin
    lim_m1 = ((CNT_W+1)'(2) << act_q) - (CNT_W+1)'(1);
    tick_o = slow_run_i && ({1'b0, cnt_q} == lim_m1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (!slow_run_i) begin
      cnt_q <= '0;
      act_q <= sel_i;
    end else if (tick_o) begin
      cnt_q <= '0;
      act_q <= sel_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_run_i && !tick_o) |=> $stable(act_q)); // R9
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      slow_sel_i,
  input  logic      tick_i,
  input  logic      wfi_i,
  input  logic      halt_i,
  input  logic      osc_keep_i,
  input  logic      irq_i,
  input  logic      ext_irq_i,
  output pmc_mode_e mode_o,
  output logic      slow_run_o
);
  pmc_mode_e mode_q, mode_d, halt_tgt, wake_tgt;

  always_comb begin
    halt_tgt = osc_keep_i ? MODE_AHALT : MODE_HALT;
    wake_tgt = slow_sel_i ? MODE_SLOW : MODE_RUN;
    mode_d   = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (halt_i)          mode_d = halt_tgt;
        else if (wfi_i)      mode_d = MODE_WAIT;
        else if (slow_sel_i) mode_d = MODE_SLOW;
      end
      MODE_SLOW: begin
        if (halt_i)                   mode_d = halt_tgt;
        else if (wfi_i)               mode_d = MODE_SWAIT;
        else if (tick_i && !slow_sel_i) mode_d = MODE_RUN;
      end
      MODE_WAIT:  if (irq_i || ext_irq_i) mode_d = MODE_RUN;
      MODE_SWAIT: if (irq_i || ext_irq_i) mode_d = MODE_SLOW;
      MODE_AHALT: if (irq_i || ext_irq_i) mode_d = wake_tgt;
      MODE_HALT:  if (ext_irq_i)          mode_d = wake_tgt;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o     = mode_q;
  assign slow_run_o = (mode_q == MODE_SLOW) || (mode_q == MODE_SWAIT);

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q <= MODE_HALT); // R2
  AST_HALT_IRQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HALT && !ext_irq_i) |=> mode_q == MODE_HALT); // R8
  AST_SLOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLOW && !tick_i && !wfi_i && !halt_i) |=> mode_q == MODE_SLOW); // R10
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAIT && !irq_i && !ext_irq_i) |=> mode_q == MODE_WAIT); // R11
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_slow_i,
  input  logic [SEL_W-1:0] cfg_div_i,
  input  logic             wfi_i,
  input  logic             halt_i,
  input  logic             osc_keep_i,
  input  logic             irq_i,
  input  logic             ext_irq_i,
  output logic             cpu_ce_o,
  output logic             per_ce_o,
  output logic             osc_en_o,
  output logic [2:0]       mode_o
);
  logic             slow_sel, slow_run, tick;
  logic [SEL_W-1:0] div_sel;
  pmc_mode_e        mode;

  pmc_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .slow_i(cfg_slow_i), .div_i(cfg_div_i),
    .slow_o(slow_sel), .div_o(div_sel)
  );

  pmc_div #(.SEL_W(SEL_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_run_i(slow_run),
    .sel_i(div_sel), .tick_o(tick)
  );

  pmc_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_sel_i(slow_sel), .tick_i(tick),
    .wfi_i(wfi_i), .halt_i(halt_i), .osc_keep_i(osc_keep_i),
    .irq_i(irq_i), .ext_irq_i(ext_irq_i),
    .mode_o(mode), .slow_run_o(slow_run)
  );

  always_comb begin
    cpu_ce_o = (mode == MODE_RUN) || (mode == MODE_SLOW && tick);
    per_ce_o = (mode == MODE_RUN) || (mode == MODE_WAIT) || (slow_run && tick);
    osc_en_o = (mode != MODE_HALT);
    mode_o   = mode;
  end

  AST_HALT_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HALT) |-> (!osc_en_o && !cpu_ce_o && !per_ce_o)); // R8
  AST_AHALT_OSC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_AHALT) |-> (osc_en_o && !cpu_ce_o && !per_ce_o)); // R7
  AST_WAIT_CPU_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_WAIT || mode == MODE_SWAIT) |-> !cpu_ce_o); // R5 R6
  AST_SWAIT_PER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SWAIT && per_ce_o) |=> !per_ce_o); // R6
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 0, slow = 0, wfi = 0, halt = 0, keep = 0, irq = 0, ext = 0;
  logic [1:0] div = 0;
  logic       cpu_ce, per_ce, osc_en;
  logic [2:0] mode;

  int checks = 0, errors = 0;
  // reference model state
  int m_mode = 0, m_cnt = 0, m_act = 0, m_div = 0;
  bit m_slow = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_slow_i(slow),
    .cfg_div_i(div), .wfi_i(wfi), .halt_i(halt), .osc_keep_i(keep),
    .irq_i(irq), .ext_irq_i(ext), .cpu_ce_o(cpu_ce), .per_ce_o(per_ce),
    .osc_en_o(osc_en), .mode_o(mode)
  );

  function automatic bit m_tick();
    return (m_mode == 1 || m_mode == 3) && (m_cnt == (2 << m_act) - 1);
  endfunction
  function automatic bit exp_cpu();
    return m_mode == 0 || (m_mode == 1 && m_tick());
  endfunction
  function automatic bit exp_per();
    return m_mode == 0 || m_mode == 2 || m_tick();
  endfunction
  function automatic string req_of(int md);
    case (md)
      0: return "R3"; 1: return "R4"; 2: return "R5";
      3: return "R6"; 4: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic model_step();
    bit t = m_tick();
    bit sr = (m_mode == 1 || m_mode == 3);
    int nm = m_mode;
    int wk = m_slow ? 1 : 0;
    case (m_mode)
      0: nm = halt ? (keep ? 4 : 5) : wfi ? 2 : m_slow ? 1 : 0;
      1: nm = halt ? (keep ? 4 : 5) : wfi ? 3 : (t && !m_slow) ? 0 : 1;
      2: nm = (irq || ext) ? 0 : 2;
      3: nm = (irq || ext) ? 1 : 3;
      4: nm = (irq || ext) ? wk : 4;
      default: nm = ext ? wk : 5;
    endcase
    if (!sr)     begin m_cnt = 0; m_act = m_div; end
    else if (t)  begin m_cnt = 0; m_act = m_div; end
    else         m_cnt = m_cnt + 1;
    m_mode = nm;
    if (we) begin m_slow = slow; m_div = int'(div); end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(int'(mode) == m_mode, "R2", "mode", int'(mode), m_mode);
    check(cpu_ce == exp_cpu(), req_of(m_mode), "cpu_ce", int'(cpu_ce), int'(exp_cpu()));
    check(per_ce == exp_per(), req_of(m_mode), "per_ce", int'(per_ce), int'(exp_per()));
    check(osc_en == (m_mode != 5), req_of(m_mode), "osc_en", int'(osc_en), int'(m_mode != 5));
  endtask

  // inputs held one cycle, then strobes cleared
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    we = 0; wfi = 0; halt = 0; irq = 0; ext = 0;
  endtask

  task automatic write_cfg(bit s, logic [1:0] d);
    we = 1; slow = s; div = d;
    step();
  endtask

  task automatic gap_to_pulse(output int n);
    n = 0;
    do begin step(); n++; end while (!per_ce && n < 40);
  endtask

  task automatic to_run();
    write_cfg(0, div);
    for (int i = 0; i < 20 && int'(mode) != 0; i++) begin
      irq = 1; ext = 1; step();
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act 0 exp 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g;
    void'($urandom(32'd4242));
    #1;
    check(mode == 3'd0 && cpu_ce && per_ce && osc_en, "R1", "reset outputs",
          int'({mode, cpu_ce, per_ce, osc_en}), 7);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    compare();
    step();

    // R4: each divider value, measured gap
    for (int d = 0; d < 4; d++) begin
      write_cfg(1, 2'(d));
      gap_to_pulse(g);
      gap_to_pulse(g);
      check(g == (2 << d), "R4", "pulse gap", g, 2 << d);
      to_run();
    end

    // R9: change from /2 to /16 just after a pulse
    write_cfg(1, 2'd0);
    gap_to_pulse(g);
    we = 1; slow = 1; div = 2'd3;
    gap_to_pulse(g);
    check(g == 2, "R9", "gap after write", g, 2);
    gap_to_pulse(g);
    check(g == 16, "R9", "gap at new rate", g, 16);

    // R10: clear slow bit mid-period, run resumes after next pulse
    step(); step();
    write_cfg(0, 2'd3);
    check(mode == 3'd1, "R10", "still slow", int'(mode), 1);
    gap_to_pulse(g);
    step();
    check(mode == 3'd0, "R10", "run after pulse", int'(mode), 0);

    // R11: wait and halt together, halt wins
    wfi = 1; halt = 1; keep = 1; step();
    check(mode == 3'd4, "R11", "halt priority", int'(mode), 4);
    wfi = 1; step();
    check(mode == 3'd4, "R11", "wait ignored in halt", int'(mode), 4);
    irq = 1; step();
    check(mode == 3'd0, "R7", "active halt wake", int'(mode), 0);

    // R8: irq ignored in Halt, ext wakes into Slow
    write_cfg(1, 2'd1);
    halt = 1; keep = 0; step();
    irq = 1; step();
    check(mode == 3'd5 && !osc_en, "R8", "irq ignored in halt", int'(mode), 5);
    ext = 1; step();
    check(mode == 3'd1, "R8", "ext wake to slow", int'(mode), 1);

    // R6: slow-wait returns to slow
    wfi = 1; step();
    check(mode == 3'd3 && !cpu_ce, "R6", "slow-wait entry", int'(mode), 3);
    irq = 1; step();
    check(mode == 3'd1, "R6", "slow-wait wake", int'(mode), 1);

    // R5: wait from run
    to_run();
    wfi = 1; step();
    check(mode == 3'd2 && per_ce && !cpu_ce, "R5", "wait outputs", int'(mode), 2);
    ext = 1; step();
    check(mode == 3'd0, "R5", "wait wake", int'(mode), 0);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      we   = ($urandom % 24) == 0;
      slow = $urandom % 2;
      div  = 2'($urandom % 4);
      wfi  = ($urandom % 20) == 0;
      halt = ($urandom % 40) == 0;
      keep = $urandom % 2;
      irq  = ($urandom % 10) == 0;
      ext  = ($urandom % 25) == 0;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule